// File: doc/BRIEF.md
# Programmable Clamp Pulse Generator

This block produces one black-level clamp pulse per video line, in the pixel clock domain. In internal mode it watches the normalized, active-high horizontal sync. When sync falls, a sequencer waits a programmed number of clocks and then holds the clamp for a programmed number of clocks. In external mode the block ignores sync. It passes an asynchronous clamp input through a two-flop synchronizer, and that input can be declared active high or active low. In both modes the output is registered and active high.

The sequencer has three states. `ST_IDLE` waits for a sync falling edge. `ST_PLACE` counts down the placement delay. `ST_CLAMP` counts down the pulse length. Its transitions are:

- **fall-restart**: from any state on a sync falling edge. It goes to `ST_PLACE`, or straight to `ST_CLAMP` if the placement is 0. It goes to `ST_IDLE` if both values are 0.
- **place-done**: `ST_PLACE` to `ST_CLAMP`, or to `ST_IDLE` if the duration is 0.
- **clamp-done**: `ST_CLAMP` to `ST_IDLE`.

A falling edge is seen at the clock edge E0 that samples sync low after it was sampled high.

Top module: `clamp_pulse_gen`

## Requirements
- R1: While reset is held and after it is released with no stimulus, `clamp_out` is 0.
- R2: In internal mode (`use_ext`=0), with placement P>0, `clamp_out` is first high after clock edge E0+P+1.
- R3: In internal mode, with duration D>0, `clamp_out` stays high for exactly D clocks and is low again after edge E0+P+D+1.
- R4: With placement 0 the sequencer enters clamping on edge E0, so `clamp_out` is high after edge E0+1.
- R5: A duration of 0 produces no pulse for any placement.
- R6: A sync falling edge during placement or clamping restarts the sequence. The new pulse is timed from the new edge alone.
- R7: In external mode (`use_ext`=1) with `ext_active_low`=0, `clamp_out` follows `ext_clamp_in` three clock edges after the input is sampled.
- R8: In external mode with `ext_active_low`=1, `clamp_out` is the inverse of the synchronized external input. A low external input therefore gives a high clamp.
- R9: In external mode the horizontal sync has no effect on `clamp_out`. In internal mode the external input has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_in | input | 1 | Normalized horizontal sync, active high |
| ext_clamp_in | input | 1 | Asynchronous external clamp request |
| place_cnt | input | 8 | Clocks from sync trailing edge to clamp start |
| dur_cnt | input | 8 | Clamp length in clocks, 0 disables the pulse |
| use_ext | input | 1 | 0: internal sequencer, 1: external clamp input |
| ext_active_low | input | 1 | External input polarity, 1 = active low |
| clamp_out | output | 1 | Clamp pulse, active high |

## Verification
Internal results have fixed deadlines measured from the edge E0:

- The rise is due after edge E0+P+1.
- The fall is due after edge E0+P+D+1.

External results have their own deadlines:

- An external change is due at the output after the third edge that follows it.
- A change of polarity or mode takes effect after one edge.

The bench drives inputs on the falling clock edge and samples 1 ns after each rising edge. It indexes every sample by the number of edges since E0, so each expectation is compared in exactly the cycle it is due. The restart cases place the second sync edge at a known index inside the placement window and inside the clamp window.

// File: rtl/clamp_pkg.sv
package clamp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PLACE = 2'd1,
        ST_CLAMP = 2'd2
    } clamp_state_t;
endpackage

// File: rtl/clamp_edge_det.sv
module clamp_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic fall_pulse
);
    logic sig_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig_in;
    end

    always_comb fall_pulse = sig_q & ~sig_in;
endmodule

// File: rtl/clamp_sync.sv
module clamp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[i] <= 1'b0;
                else        chain[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[i] <= 1'b0;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    always_comb q = chain[STAGES-1];
endmodule

// File: rtl/clamp_seq.sv
module clamp_seq
    import clamp_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fall,
    input  logic [CW-1:0] place,
    input  logic [CW-1:0] dur,
    output logic          active
);
    localparam logic [CW-1:0] ONE  = CW'(1);
    localparam logic [CW-1:0] ZERO = '0;

    clamp_state_t  state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= ZERO;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (fall) begin
            if (place != ZERO) begin
                state_d = ST_PLACE;
                cnt_d   = place - ONE;
            end else if (dur != ZERO) begin
                state_d = ST_CLAMP;
                cnt_d   = dur - ONE;
            end else begin
                state_d = ST_IDLE;
                cnt_d   = ZERO;
            end
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    cnt_d = ZERO;
                end
                ST_PLACE: begin
                    if (cnt_q != ZERO) begin
                        cnt_d = cnt_q - ONE;
                    end else if (dur != ZERO) begin
                        state_d = ST_CLAMP;
                        cnt_d   = dur - ONE;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
                ST_CLAMP: begin
                    if (cnt_q != ZERO) cnt_d = cnt_q - ONE;
                    else               state_d = ST_IDLE;
                end
                default: begin
                    state_d = ST_IDLE;
                    cnt_d   = ZERO;
                end
            endcase
        end
    end

    always_comb active = (state_q == ST_CLAMP);

    assert_no_pulse_zero_dur_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dur == ZERO) |=> !$rose(active));

    assert_restart_to_place_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fall && place != ZERO) |=> (state_q == ST_PLACE));
endmodule

// File: rtl/clamp_pulse_gen.sv
module clamp_pulse_gen #(
    parameter int CW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hsync_in,
    input  logic          ext_clamp_in,
    input  logic [CW-1:0] place_cnt,
    input  logic [CW-1:0] dur_cnt,
    input  logic          use_ext,
    input  logic          ext_active_low,
    output logic          clamp_out
);
    logic hs_fall;
    logic seq_active;
    logic ext_sync;

    clamp_edge_det u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .sig_in     (hsync_in),
        .fall_pulse (hs_fall)
    );

    clamp_seq #(.CW(CW)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .fall   (hs_fall),
        .place  (place_cnt),
        .dur    (dur_cnt),
        .active (seq_active)
    );

    clamp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ext_clamp_in),
        .q     (ext_sync)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       clamp_out <= 1'b0;
        else if (use_ext) clamp_out <= ext_sync ^ ext_active_low;
        else              clamp_out <= seq_active;
    end

    assert_ext_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (use_ext && !ext_active_low) |=> (clamp_out == $past(ext_sync)));

    assert_ext_invert_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (use_ext && ext_active_low) |=> (clamp_out == !$past(ext_sync)));

    assert_int_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !use_ext |=> (clamp_out == $past(seq_active)));
endmodule

// File: tb/clamp_pulse_gen_test.sv
`timescale 1ns/1ps
module clamp_pulse_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hsync_in = 1'b0;
    logic       ext_clamp_in = 1'b0;
    logic [7:0] place_cnt = 8'd0;
    logic [7:0] dur_cnt = 8'd0;
    logic       use_ext = 1'b0;
    logic       ext_active_low = 1'b0;
    logic       clamp_out;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    clamp_pulse_gen uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .hsync_in       (hsync_in),
        .ext_clamp_in   (ext_clamp_in),
        .place_cnt      (place_cnt),
        .dur_cnt        (dur_cnt),
        .use_ext        (use_ext),
        .ext_active_low (ext_active_low),
        .clamp_out      (clamp_out)
    );

    // {placement, duration}
    localparam logic [15:0] VEC_TABLE [0:10] = '{
        16'h0001, 16'h0005, 16'h0101, 16'h0304, 16'h0A02, 16'h0000,
        16'h0700, 16'h0214, 16'h8080, 16'hFF03, 16'h05FF
    };

    task automatic sample(input logic exp, input string tag);
        @(posedge clk); #1;
        n_checks++;
        if (clamp_out !== exp) begin
            n_fail++;
            $display("FAIL %s: clamp_out=%b expected=%b", tag, clamp_out, exp);
        end
    endtask

    // Sync high for a few clocks, then low before the next rising edge (E0).
    task automatic sync_fall();
        @(negedge clk) hsync_in = 1'b1;
        repeat (3) @(negedge clk);
        hsync_in = 1'b0;
    endtask

    // Samples after edges E0+kstart .. E0+kend; one check per window.
    task automatic run_window(input int p, input int d, input int kstart,
                              input int kend, input string tag);
        int   bad_k;
        logic bad_v;
        bad_k = -1;
        bad_v = 1'b0;
        for (int k = kstart; k <= kend; k++) begin
            logic exp;
            @(posedge clk); #1;
            exp = (d > 0) && (k >= p + 1) && (k <= p + d);
            if (clamp_out !== exp && bad_k < 0) begin
                bad_k = k;
                bad_v = clamp_out;
            end
        end
        n_checks++;
        if (bad_k >= 0) begin
            n_fail++;
            $display("FAIL %s: P=%0d D=%0d at edge E0+%0d clamp_out=%b expected=%b",
                     tag, p, d, bad_k, bad_v, !bad_v);
        end
    endtask

    initial begin
        // R1: reset state
        #1;
        n_checks++;
        if (clamp_out !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: clamp_out=%b expected=0 in reset", clamp_out);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        sample(1'b0, "R1 after reset");
        sample(1'b0, "R1 after reset");

        // Vector table: R2, R3, R4, R5
        for (int i = 0; i < 11; i++) begin
            int p;
            int d;
            p = int'(VEC_TABLE[i][15:8]);
            d = int'(VEC_TABLE[i][7:0]);
            @(negedge clk);
            place_cnt = VEC_TABLE[i][15:8];
            dur_cnt   = VEC_TABLE[i][7:0];
            sync_fall();
            run_window(p, d, 0, p + d + 3,
                       (d == 0) ? "R5 zero duration" :
                       (p == 0) ? "R4 zero placement" : "R2/R3 placement and duration");
        end

        // R6: restart during placement (P=6, D=4), second edge 4 clocks after E0
        @(negedge clk);
        place_cnt = 8'd6;
        dur_cnt   = 8'd4;
        sync_fall();
        for (int k = 0; k < 3; k++) sample(1'b0, "R6 placement before restart");
        @(negedge clk) hsync_in = 1'b1;
        sample(1'b0, "R6 placement before restart");
        @(negedge clk) hsync_in = 1'b0;
        run_window(6, 4, 0, 13, "R6 restart in placement");

        // R6: restart during clamping (P=1, D=10)
        @(negedge clk);
        place_cnt = 8'd1;
        dur_cnt   = 8'd10;
        sync_fall();
        sample(1'b0, "R6 clamp-phase k0");
        sample(1'b0, "R6 clamp-phase k1");
        sample(1'b1, "R6 clamp-phase k2");
        sample(1'b1, "R6 clamp-phase k3");
        @(negedge clk) hsync_in = 1'b1;
        sample(1'b1, "R6 clamp-phase k4");
        @(negedge clk) hsync_in = 1'b0;
        sample(1'b1, "R6 restart edge still clamping");
        run_window(1, 10, 1, 14, "R6 restart in clamping");

        // R9: internal mode ignores the external input
        @(negedge clk) ext_clamp_in = 1'b1;
        for (int k = 0; k < 5; k++) sample(1'b0, "R9 ext ignored in internal mode");
        @(negedge clk) ext_clamp_in = 1'b0;
        repeat (3) @(negedge clk);

        // R7: external mode, active high
        @(negedge clk);
        use_ext = 1'b1;
        ext_active_low = 1'b0;
        sample(1'b0, "R7 ext low");
        @(negedge clk) ext_clamp_in = 1'b1;
        sample(1'b0, "R7 latency edge 1");
        sample(1'b0, "R7 latency edge 2");
        sample(1'b1, "R7 latency edge 3");

        // R9: sync ignored in external mode
        place_cnt = 8'd0;
        dur_cnt   = 8'd2;
        sync_fall();
        for (int k = 0; k < 5; k++) sample(1'b1, "R9 sync ignored in ext mode (high)");
        @(negedge clk) ext_clamp_in = 1'b0;
        sample(1'b1, "R7 fall latency edge 1");
        sample(1'b1, "R7 fall latency edge 2");
        sample(1'b0, "R7 fall latency edge 3");
        sync_fall();
        for (int k = 0; k < 5; k++) sample(1'b0, "R9 sync ignored in ext mode (low)");

        // R8: active-low external input
        @(negedge clk) ext_active_low = 1'b1;
        sample(1'b1, "R8 low input gives clamp");
        @(negedge clk) ext_clamp_in = 1'b1;
        sample(1'b1, "R8 latency edge 1");
        sample(1'b1, "R8 latency edge 2");
        sample(1'b0, "R8 high input releases clamp");

        // Back to internal mode: idle sequencer gives 0
        @(negedge clk);
        use_ext = 1'b0;
        ext_active_low = 1'b0;
        sample(1'b0, "R9 internal mode idle");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule